// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches a bank of general-purpose input pins and turns activity on them into per-pin interrupt requests. Every pin has four trigger enables: rising edge, falling edge, high level and low level. Any mix of them may be set on the same pin. When an enabled condition is seen, the pin's status bit is set and stays set until software clears it by writing a one to that bit. The status bits are set whether or not the pin's interrupt is unmasked. A separate mask register decides which status bits reach the interrupt outputs. A test register lets software set status bits directly, without any pin activity.

Pin inputs are asynchronous. They pass through a two-stage synchronizer before any detection. An edge is found by comparing the synchronized value with the value from one cycle earlier. After reset, edge detection stays off until a genuine earlier sample exists, so a pin that is already high when reset ends does not create a rising edge.

Software uses a plain register port. A write takes effect on the clock edge on which the write strobe is high. Read data is combinational from the address. The port has no handshake and no back-pressure: each access completes in the cycle it is presented. The pins and the interrupt outputs are plain level signals, with no flow control.

Top module: `pin_irq_ctrl`

## Requirements
- R1: With the rising-edge enable of a pin set (address 3), a 0-to-1 change on that pin sets its status bit (address 0). The bit is set by the third clock edge after the pin changes, and is still clear after the second.
- R2: With the falling-edge enable of a pin set (address 4), a 1-to-0 change on that pin sets its status bit, with the same three-edge latency as R1.
- R3: While a pin is high and its high-level enable (address 5) is set, or while it is low and its low-level enable (address 6) is set, its status bit is set on every clock edge. Enables of different kinds may be set on the same pin together.
- R4: Pin changes and levels whose trigger enable is clear leave the status bits unchanged.
- R5: Status bits are sticky. Writing a 1 to a bit of address 0 clears that bit. Writing 0 leaves it unchanged.
- R6: When a clear and a set reach the same status bit in the same cycle, the set wins. A level condition that is still true therefore keeps the bit set through a clear write.
- R7: Writing a 1 to a bit of the test register (address 2) sets the matching status bit on that write's clock edge. The test register is not stored and always reads as zero.
- R8: Each interrupt output is its status bit ANDed with the matching mask bit (address 1). Masking does not stop status bits from being set.
- R9: After reset, all registers read zero. A pin that is high when reset is released does not produce a rising-edge event.
- R10: The mask and the four enable registers read back the last value written. Address 7 returns the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| irq_o | output | NUM_PINS | Masked per-pin interrupt requests |

## Verification
The hardest case to reach from the ports is a clear and a set landing on the same status bit in the same cycle. Edge events last only one cycle, and they arrive three edges after the pin moves. The bench gets there with level triggers instead: it holds a level condition true so that an event is present in every cycle, and then issues the clear write. A correct design keeps the bit set. A second hard case is the false edge after reset. To reach it, the bench holds every pin high through reset and enables rising-edge detection on the first edge after release, while the synchronizer is still filling.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Register word addresses of the software port
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_MASK   = 3'd1,
    REG_FORCE  = 3'd2,
    REG_RISE   = 3'd3,
    REG_FALL   = 3'd4,
    REG_HIGH   = 3'd5,
    REG_LOW    = 3'd6,
    REG_LEVEL  = 3'd7
  } reg_sel_e;

  localparam int unsigned REG_ADDR_W = 3;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o,
  output logic             level_ok_o,
  output logic             edge_ok_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;
  logic [STAGES:0]  fill_q;

  // Synchronizer chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pins_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  // Previous sample and pipeline fill tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= stage_q[LAST];
      fill_q <= {fill_q[STAGES-1:0], 1'b1};
    end
  end

  assign sync_o     = stage_q[LAST];
  assign prev_o     = prev_q;
  assign level_ok_o = fill_q[LAST];
  assign edge_ok_o  = fill_q[STAGES];

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic             level_ok_i,
  input  logic             edge_ok_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  input  logic [WIDTH-1:0] high_en_i,
  input  logic [WIDTH-1:0] low_en_i,
  output logic [WIDTH-1:0] event_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic up_hit, down_hit, high_hit, low_hit;

    assign up_hit   = edge_ok_i  & rise_en_i[g] &  sync_i[g] & ~prev_i[g];
    assign down_hit = edge_ok_i  & fall_en_i[g] & ~sync_i[g] &  prev_i[g];
    assign high_hit = level_ok_i & high_en_i[g] &  sync_i[g];
    assign low_hit  = level_ok_i & low_en_i[g]  & ~sync_i[g];

    assign event_o[g] = up_hit | down_hit | high_hit | low_hit;

    p_rise_event_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_ok_i && rise_en_i[g] && $rose(sync_i[g])) |-> event_o[g]);

    p_fall_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_ok_i && fall_en_i[g] && $fell(sync_i[g])) |-> event_o[g]);
  end

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [PINS-1:0]       event_i,
  input  logic [PINS-1:0]       level_i,
  output logic [PINS-1:0]       rise_en_o,
  output logic [PINS-1:0]       fall_en_o,
  output logic [PINS-1:0]       high_en_o,
  output logic [PINS-1:0]       low_en_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [PINS-1:0]       irq_o
);

  reg_sel_e        sel;
  logic [PINS-1:0] wbits;
  logic [PINS-1:0] status_q, mask_q;
  logic [PINS-1:0] rise_q, fall_q, high_q, low_q;
  logic [PINS-1:0] clr_vec, force_vec, set_vec;

  assign sel   = reg_sel_e'(addr_i);
  assign wbits = wdata_i[PINS-1:0];

  assign clr_vec   = (we_i && sel == REG_STATUS) ? wbits : '0;
  assign force_vec = (we_i && sel == REG_FORCE)  ? wbits : '0;
  assign set_vec   = event_i | force_vec;

  // Sticky status, set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;
  end

  // Control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (we_i) begin
      case (sel)
        REG_MASK: mask_q <= wbits;
        REG_RISE: rise_q <= wbits;
        REG_FALL: fall_q <= wbits;
        REG_HIGH: high_q <= wbits;
        REG_LOW:  low_q  <= wbits;
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_STATUS: rdata_o[PINS-1:0] = status_q;
      REG_MASK:   rdata_o[PINS-1:0] = mask_q;
      REG_RISE:   rdata_o[PINS-1:0] = rise_q;
      REG_FALL:   rdata_o[PINS-1:0] = fall_q;
      REG_HIGH:   rdata_o[PINS-1:0] = high_q;
      REG_LOW:    rdata_o[PINS-1:0] = low_q;
      REG_LEVEL:  rdata_o[PINS-1:0] = level_i;
      default:    rdata_o = '0;
    endcase
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign high_en_o = high_q;
  assign low_en_o  = low_q;
  assign irq_o     = status_q & mask_q;

  // A status bit only drops when a clear write hit it
  p_sticky_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));

  // Any set request lands in status on the next edge, clear or not
  p_set_beats_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // The test register is write-only
  p_force_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REG_FORCE) |-> (rdata_o == '0));

  // Output never raised without status behind it
  p_irq_needs_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~status_q) == '0) && ((irq_o & ~mask_q) == '0));

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_PINS-1:0]   irq_o
);

  logic [NUM_PINS-1:0] sync_lvl, prev_lvl, events;
  logic [NUM_PINS-1:0] rise_en, fall_en, high_en, low_en;
  logic                level_ok, edge_ok;

  pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_i     (pins_i),
    .sync_o     (sync_lvl),
    .prev_o     (prev_lvl),
    .level_ok_o (level_ok),
    .edge_ok_o  (edge_ok)
  );

  pin_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_lvl),
    .prev_i     (prev_lvl),
    .level_ok_i (level_ok),
    .edge_ok_i  (edge_ok),
    .rise_en_i  (rise_en),
    .fall_en_i  (fall_en),
    .high_en_i  (high_en),
    .low_en_i   (low_en),
    .event_o    (events)
  );

  pin_irq_regs #(.PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .event_i   (events),
    .level_i   (sync_lvl),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .high_en_o (high_en),
    .low_en_o  (low_en),
    .rdata_o   (reg_rdata_o),
    .irq_o     (irq_o)
  );

  // A pin held high across reset release must not look like a rising edge
  p_no_edge_before_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_ok |-> ((events & ~(high_en & sync_lvl) & ~(low_en & ~sync_lvl)) == '0));

endmodule

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_MASK   = 3'd1;
  localparam logic [2:0] A_FORCE  = 3'd2;
  localparam logic [2:0] A_RISE   = 3'd3;
  localparam logic [2:0] A_FALL   = 3'd4;
  localparam logic [2:0] A_HIGH   = 3'd5;
  localparam logic [2:0] A_LOW    = 3'd6;
  localparam logic [2:0] A_LEVEL  = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) rd_chk("R9 reset value", 3'(a), 32'h0);
    chk("R9 irq at reset", irq, 32'h0);
    @(negedge clk);
    wr(A_RISE, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rd_chk("R9 no false edge", A_STATUS, 32'h0);
    rd_chk("R10 level readback", A_LEVEL, 32'hFFFF_FFFF);
    wr(A_RISE, 32'h0);
  endtask

  task automatic t_disabled;
    pins = 32'h0;
    repeat (4) @(negedge clk);
    rd_chk("R4 fall ignored", A_STATUS, 32'h0);
    pins = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rd_chk("R4 rise ignored", A_STATUS, 32'h0);
    pins = 32'h0;
    repeat (4) @(negedge clk);
    rd_chk("R4 levels ignored", A_STATUS, 32'h0);
  endtask

  task automatic t_rising;
    wr(A_RISE, 32'h0000_FFFF);
    rd_chk("R10 rise readback", A_RISE, 32'h0000_FFFF);
    pins = 32'hA5A5_A5A5;
    repeat (2) @(negedge clk);
    rd_chk("R1 latency not yet", A_STATUS, 32'h0);
    @(negedge clk);
    rd_chk("R1 rising set", A_STATUS, 32'h0000_A5A5);
    pins = 32'h0;
    repeat (4) @(negedge clk);
    rd_chk("R4 falling without enable", A_STATUS, 32'h0000_A5A5);
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd_chk("R5 clear all", A_STATUS, 32'h0);
    wr(A_RISE, 32'h0);
  endtask

  task automatic t_falling;
    pins = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    wr(A_FALL, 32'hFF00_FF00);
    rd_chk("R10 fall readback", A_FALL, 32'hFF00_FF00);
    pins = 32'h0F0F_0F0F;
    repeat (2) @(negedge clk);
    rd_chk("R2 latency not yet", A_STATUS, 32'h0);
    @(negedge clk);
    rd_chk("R2 falling set", A_STATUS, 32'hF000_F000);
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd_chk("R5 clear after fall", A_STATUS, 32'h0);
    wr(A_FALL, 32'h0);
  endtask

  task automatic t_level;
    // pins = 0F0F0F0F here
    wr(A_HIGH, 32'h0000_00FF);
    wr(A_LOW,  32'h0000_FF00);
    @(negedge clk);
    rd_chk("R3 high and low levels", A_STATUS, 32'h0000_F00F);
    rd_chk("R10 high readback", A_HIGH, 32'h0000_00FF);
    rd_chk("R10 low readback", A_LOW, 32'h0000_FF00);
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd_chk("R6 set wins over clear", A_STATUS, 32'h0000_F00F);
    wr(A_HIGH, 32'h0);
    wr(A_LOW, 32'h0);
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd_chk("R5 clear once level disabled", A_STATUS, 32'h0);
    // rise and high level together on pin 4 (pin 4 is low now)
    wr(A_RISE, 32'h0000_0010);
    wr(A_HIGH, 32'h0000_0010);
    pins = 32'h0F0F_0F1F;
    repeat (3) @(negedge clk);
    rd_chk("R3 combined enables", A_STATUS, 32'h0000_0010);
    wr(A_RISE, 32'h0);
    wr(A_HIGH, 32'h0);
    wr(A_STATUS, 32'hFFFF_FFFF);
    pins = 32'h0F0F_0F0F;
  endtask

  task automatic t_sticky;
    pins = 32'h0F0F_0F0E;
    repeat (4) @(negedge clk);
    wr(A_RISE, 32'h0000_0001);
    pins = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    pins = 32'h0F0F_0F0E;
    repeat (8) @(negedge clk);
    rd_chk("R5 bit held after pulse", A_STATUS, 32'h1);
    wr(A_STATUS, 32'h0);
    rd_chk("R5 write zero keeps", A_STATUS, 32'h1);
    wr(A_STATUS, 32'h20);
    rd_chk("R5 other bit write keeps", A_STATUS, 32'h1);
    wr(A_STATUS, 32'h1);
    rd_chk("R5 write one clears", A_STATUS, 32'h0);
    wr(A_RISE, 32'h0);
  endtask

  task automatic t_force_mask;
    wr(A_MASK, 32'h0000_0003);
    rd_chk("R10 mask readback", A_MASK, 32'h0000_0003);
    wr(A_FORCE, 32'h0000_0101);
    rd_chk("R7 force sets status", A_STATUS, 32'h0000_0101);
    chk("R8 irq masked", irq, 32'h0000_0001);
    rd_chk("R7 force reads zero", A_FORCE, 32'h0);
    repeat (2) @(negedge clk);
    rd_chk("R5 forced bits stay", A_STATUS, 32'h0000_0101);
    wr(A_STATUS, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd_chk("R7 force not stored", A_STATUS, 32'h0);
    chk("R8 irq low after clear", irq, 32'h0);
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_FORCE, 32'h8000_0000);
    chk("R8 irq unmasked", irq, 32'h8000_0000);
    wr(A_MASK, 32'h0);
    chk("R8 irq masked off", irq, 32'h0);
    rd_chk("R8 status kept under mask", A_STATUS, 32'h8000_0000);
    wr(A_STATUS, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_rising();
    t_falling();
    t_level();
    t_sticky();
    t_force_mask();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule